// File: doc/BRIEF.md
# Single-Accumulator Eight-Opcode Processor

This block is a small stored-program processor built around one working register, the accumulator. Every instruction is one 12-bit word: a 3-bit opcode in bits 11..9 and a 9-bit direct address in bits 8..0. The core fetches each word from a single word-addressed memory and then executes it in a second cycle. The operation uses the accumulator, the program counter and, for the increment-and-skip opcode, a read-modify-write of the addressed word.

There are no compare-and-branch instructions. A loop counts a memory word up towards zero and skips the closing jump once that word wraps. Subroutines are entered by an instruction that plants a return jump at the head of the subroutine. The subroutine returns by jumping to that head. A store always leaves the accumulator cleared. Output goes to a latched register with a single-cycle strobe. The operate group gives clear, complement, increment and halt.

The memory sits outside the block. The read port is combinational: read data belongs to the address driven in the same cycle. A write is taken at the rising clock edge when the write enable is high.

Top module: `acc_core`

## Requirements
- R1: While reset (active low) is held, the core shows halted low, output strobe low, write enable low and memory address 0. After release, the first fetch is from address 0, with the accumulator at 0.
- R2: Each instruction takes two cycles. The fetch cycle reads the word at the program counter and advances the counter by one. The execute cycle uses address bits 8..0 and opcode bits 11..9, with the codes AND=0, TAD=1, ISZ=2, DCA=3, JMS=4, JMP=5, IOT=6, OPR=7.
- R3: AND (code 0) sets the accumulator to its bitwise AND with the addressed word.
- R4: TAD (code 1) adds the addressed word into the accumulator modulo 4096, dropping the carry out of bit 11.
- R5: ISZ (code 2) writes the addressed word plus one (modulo 4096) back to the same address. When that result is zero, the next instruction is skipped.
- R6: DCA (code 3) writes the accumulator to the addressed word and leaves the accumulator at zero.
- R7: JMS (code 4) writes a JMP word, 0xA00 OR the return address, to the target and continues at target+1. The return address is the address after the JMS. JMP (code 5) continues at its address, so a JMP to the subroutine head returns.
- R8: IOT (code 6) copies the accumulator to the output port and raises the output strobe for exactly one cycle.
- R9: OPR (code 7) acts on the accumulator in a fixed order: bit 7 clears it, then bit 5 complements it, then bit 0 increments it (modulo 4096).
- R10: OPR with bit 1 set halts the core after the other OPR actions. Halted stays high until reset, with no further strobes or memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| memAddr | output | 9 | Memory word address |
| memRData | input | 12 | Memory read data for memAddr, combinational |
| memWe | output | 1 | Memory write enable, taken at the clock edge |
| memWData | output | 12 | Memory write data |
| outData | output | 12 | Output register loaded by IOT |
| outStrobe | output | 1 | One-cycle pulse after each IOT |
| halted | output | 1 | High once a halt has executed |

## Verification
The increment-and-skip instruction does two things in one execute cycle. It writes back the incremented word, and it decides whether the counter jumps over the next instruction. Both actions rest on the same incremented value. The program runs the instruction once on a word of 0xFFF, which wraps to zero and must skip, and once on a word of 3, which must not skip. The skipped slot holds an accumulator-changing operate word. A wrong skip therefore shows up as a wrong value in the next output strobe, and the memory words read after halt show whether the write-back took place.

// File: rtl/acc_pkg.sv
package acc_pkg;
  parameter int WORD_W = 12;
  parameter int ADDR_W = 9;
  localparam int OP_W = WORD_W - ADDR_W;

  parameter int OPR_CLA_BIT = 7;
  parameter int OPR_CMA_BIT = 5;
  parameter int OPR_IAC_BIT = 0;
  parameter int OPR_HLT_BIT = 1;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'd0, OP_TAD = 3'd1, OP_ISZ = 3'd2, OP_DCA = 3'd3,
    OP_JMS = 3'd4, OP_JMP = 3'd5, OP_IOT = 3'd6, OP_OPR = 3'd7
  } opcode_e;

  typedef struct packed {
    logic fetch;
    logic doAnd;
    logic doTad;
    logic doIsz;
    logic doDca;
    logic doJms;
    logic doJmp;
    logic doIot;
    logic doOpr;
    logic [ADDR_W-1:0] addr;
  } ctrl_t;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] memRData,
  output ctrl_t             ctl,
  output logic              halted
);
  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} state_e;

  state_e state;
  logic [WORD_W-1:0] instrReg;
  opcode_e opcode;

  assign opcode = opcode_e'(instrReg[WORD_W-1:ADDR_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_FETCH;
      instrReg <= '0;
    end else begin
      case (state)
        ST_FETCH: begin
          instrReg <= memRData;
          state    <= ST_EXEC;
        end
        ST_EXEC: begin
          if (opcode == OP_OPR && instrReg[OPR_HLT_BIT]) state <= ST_HALT;
          else state <= ST_FETCH;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.fetch = (state == ST_FETCH);
    ctl.addr  = instrReg[ADDR_W-1:0];
    if (state == ST_EXEC) begin
      ctl.doAnd = (opcode == OP_AND);
      ctl.doTad = (opcode == OP_TAD);
      ctl.doIsz = (opcode == OP_ISZ);
      ctl.doDca = (opcode == OP_DCA);
      ctl.doJms = (opcode == OP_JMS);
      ctl.doJmp = (opcode == OP_JMP);
      ctl.doIot = (opcode == OP_IOT);
      ctl.doOpr = (opcode == OP_OPR);
    end
  end

  assign halted = (state == ST_HALT);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R2
  fetch_exec_alt_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fetch |=> !ctl.fetch);
endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [WORD_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [WORD_W-1:0] memWData,
  output logic [WORD_W-1:0] outData,
  output logic              outStrobe
);
  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] incWord;
  logic [WORD_W-1:0] oprResult;
  logic              incZero;

  assign incWord = memRData + 1'b1;
  assign incZero = (incWord == '0);

  // operate group, applied in order clear, complement, increment
  always_comb begin
    oprResult = acc;
    if (ctl.addr[OPR_CLA_BIT]) oprResult = '0;
    if (ctl.addr[OPR_CMA_BIT]) oprResult = ~oprResult;
    if (ctl.addr[OPR_IAC_BIT]) oprResult = oprResult + 1'b1;
  end

  assign memAddr = ctl.fetch ? pc : ctl.addr;
  assign memWe   = ctl.doIsz | ctl.doDca | ctl.doJms;

  always_comb begin
    memWData = acc;
    if (ctl.doIsz) memWData = incWord;
    else if (ctl.doJms) memWData = {OP_JMP, pc};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc        <= '0;
      acc       <= '0;
      outData   <= '0;
      outStrobe <= 1'b0;
    end else begin
      outStrobe <= ctl.doIot;
      if (ctl.doIot) outData <= acc;

      if (ctl.fetch) pc <= pc + 1'b1;
      else if (ctl.doIsz && incZero) pc <= pc + 1'b1;
      else if (ctl.doJms) pc <= ctl.addr + 1'b1;
      else if (ctl.doJmp) pc <= ctl.addr;

      if (ctl.doAnd) acc <= acc & memRData;
      else if (ctl.doTad) acc <= acc + memRData;
      else if (ctl.doDca) acc <= '0;
      else if (ctl.doOpr) acc <= oprResult;
    end
  end

  // R8
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outStrobe |=> !outStrobe);

  // R6
  dca_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doDca |=> (acc == '0));

  // R4
  tad_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doTad |=> (acc == WORD_W'($past(acc) + $past(memRData))));

  // R5
  isz_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doIsz && memRData == '1) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  // R5
  isz_noskip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doIsz && memRData != '1) |=> $stable(pc));

  // R7
  jms_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doJms |=> (pc == ADDR_W'($past(ctl.addr) + 1'b1)));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memRData,
  output logic              memWe,
  output logic [WORD_W-1:0] memWData,
  output logic [WORD_W-1:0] outData,
  output logic              outStrobe,
  output logic              halted
);
  ctrl_t ctl;

  acc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .memRData (memRData),
    .ctl      (ctl),
    .halted   (halted)
  );

  acc_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .memRData  (memRData),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memWData  (memWData),
    .outData   (outData),
    .outStrobe (outStrobe)
  );

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!memWe && !outStrobe));
endmodule

// File: tb/acc_core_test.sv
module acc_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 2000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  memAddr;
  logic [11:0] memRData;
  logic        memWe;
  logic [11:0] memWData;
  logic [11:0] outData;
  logic        outStrobe;
  logic        halted;

  logic [11:0] mem [512];
  logic [11:0] expQ [$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core uut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRData(memRData),
    .memWe(memWe), .memWData(memWData), .outData(outData),
    .outStrobe(outStrobe), .halted(halted)
  );

  assign memRData = mem[memAddr];
  always @(posedge clk) if (memWe) mem[memAddr] <= memWData;

  function automatic logic [11:0] enc(input int op, input int addr);
    return 12'((op << 9) | addr);
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushExp(input logic [11:0] v);
    expQ.push_back(v);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outStrobe && !done) begin
      if (expQ.size() == 0) check("R8 unexpected strobe", outData, 12'hxxx);
      else check("R8 output value", outData, expQ.pop_front());
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 12'h000;
    // main line
    mem[0]   = enc(1, 100);    // TAD 100 -> 5 (R4)
    mem[1]   = enc(1, 101);    // TAD 101 -> 3, carry dropped (R4)
    mem[2]   = enc(6, 0);      // IOT 3
    mem[3]   = enc(0, 102);    // AND 102 -> 2 (R3)
    mem[4]   = enc(6, 0);      // IOT 2
    mem[5]   = enc(3, 103);    // DCA 103 (R6)
    mem[6]   = enc(6, 0);      // IOT 0
    mem[7]   = enc(2, 104);    // ISZ wraps -> skip (R5)
    mem[8]   = 12'hEA0;        // OPR clear+complement, must be skipped
    mem[9]   = enc(2, 105);    // ISZ 3 -> 4, no skip (R5)
    mem[10]  = enc(6, 0);      // IOT 0
    mem[11]  = enc(4, 200);    // JMS 200 (R7)
    mem[12]  = 12'hE81;        // OPR clear+increment -> 1 (R9)
    mem[13]  = enc(6, 0);      // IOT 1
    mem[14]  = 12'hE22;        // OPR complement+halt -> FFE, halt (R10)
    mem[15]  = enc(6, 0);      // must not run
    // data
    mem[100] = 12'h005;
    mem[101] = 12'hFFE;
    mem[102] = 12'h00A;
    mem[103] = 12'h777;
    mem[104] = 12'hFFF;
    mem[105] = 12'h003;
    // subroutine
    mem[201] = enc(1, 100);    // TAD 100 -> 5
    mem[202] = 12'hE21;        // OPR complement then increment -> FFB (R9)
    mem[203] = enc(6, 0);      // IOT FFB
    mem[204] = enc(5, 200);    // JMP 200 -> return (R7)

    pushExp(12'h003); // R4
    pushExp(12'h002); // R3
    pushExp(12'h000); // R6
    pushExp(12'h000); // R5 skip kept AC at 0
    pushExp(12'hFFB); // R9
    pushExp(12'h001); // R7 return then R9

    repeat (3) @(negedge clk);
    check("R1 halted in reset", {11'd0, halted}, 12'h000);
    check("R1 strobe in reset", {11'd0, outStrobe}, 12'h000);
    check("R1 write enable in reset", {11'd0, memWe}, 12'h000);
    check("R1 address in reset", {3'd0, memAddr}, 12'h000);
    rstN = 1'b1;

    begin : run
      int cyc;
      cyc = 0;
      while (!halted && cyc < WDOG_CYCLES) begin
        @(negedge clk);
        cyc++;
      end
      if (!halted) check("R10 watchdog expired", {11'd0, halted}, 12'h001);
    end
    repeat (20) @(negedge clk);
    done = 1'b1;

    check("R10 halted stays high", {11'd0, halted}, 12'h001);
    check("R8 all outputs seen", 12'(expQ.size()), 12'h000);
    check("R6 DCA stored word", mem[103], 12'h002);
    check("R5 ISZ wrap written back", mem[104], 12'h000);
    check("R5 ISZ plain increment written back", mem[105], 12'h004);
    check("R7 JMS planted return jump", mem[200], 12'hA0C);
    check("R2 untouched data word", mem[100], 12'h005);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule